// File: doc/BRIEF.md
# Page-Buffered Byte Load Controller

This block is the write front end of a byte-wide nonvolatile memory model. It watches the memory's strobe bus, already sampled on the system clock: active-low chip select, write strobe and output enable, an address and a data byte. Each write cycle on that bus drops one byte into a page buffer. Loads keep gathering into the same page for as long as each one starts within a byte-load window of the one before. When the window runs out, a self-timed programming cycle starts and writes the gathered bytes into a register array in one step.

The window and the programming time are counted in clock cycles. Both are parameters. The address is split into a page number and an offset within the page. The first accepted load of an operation fixes the page number. Later loads to any other page are dropped and raise a sticky error flag. A plain registered read port lets the surrounding model read the array.

The bus uses strobes, not a valid/ready handshake, so the block cannot apply back-pressure. The `busy` flag is the only flow signal. A host must wait for `busy` to drop before it starts the next operation, because any write cycle begun while `busy` is high is ignored.

Top module: `page_load_ctrl`

## Requirements
- R1: A write cycle exists only while `ce_n` and `we_n` are both low and `oe_n` is high. If `oe_n` is low, no byte is loaded and no operation starts, whatever the other strobes do.
- R2: The address is taken in the cycle where the write condition first becomes true, which is the later of the two falling strobes. Address changes after that cycle do not move the byte.
- R3: The data byte is taken in the cycle where `ce_n` or `we_n` first returns high, whichever rises first.
- R4: A page number is the address bits above the low PAGE_W bits. After the first load of an operation, a load to another page is dropped and sets `page_err`. `page_err` stays set until reset, and the dropped load does not restart the window.
- R5: If a new write cycle opens no more than WINDOW_CYC cycles after the previous accepted one opened, it joins the page. Otherwise programming begins on the cycle after the window expires, and a write opening on that cycle or later is lost. Only the loaded bytes are written, and the other bytes of the page keep their values.
- R6: `busy` stays high for exactly PROG_CYC cycles. The array changes on the clock edge where `busy` falls, and reads before that edge return the old contents.
- R7: A write cycle that opens while `busy` is high changes no array byte and starts no new operation.
- R8: Pulsing `oe_n` low while `ce_n` and `we_n` are high between loads does not end the page operation.
- R9: After reset, `busy` and `page_err` are low and every array byte reads ERASED (0xFF by default).
- R10: A single operation can load every byte of a page, up to 2^PAGE_W bytes.
- R11: If `oe_n` falls while `ce_n` and `we_n` are still low, the write cycle is abandoned and its byte is not loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip select, active low, synchronous sample |
| we_n | input | 1 | Write strobe, active low, synchronous sample |
| oe_n | input | 1 | Output enable, active low, synchronous sample |
| addr | input | ADDR_W | Byte address of the bus cycle |
| din | input | 8 | Write data byte |
| rd_addr | input | ADDR_W | Array read address |
| rd_data | output | 8 | Array byte at `rd_addr`, one cycle later |
| busy | output | 1 | Programming cycle in progress |
| page_err | output | 1 | Sticky flag: a load to another page was dropped |

## Verification
The hardest cases to reach are the two edges of the byte-load window, and the mismatched load that has to leave the window timer alone. Both depend on where a strobe lands to the exact clock cycle. The bench drives each such test from a loop that numbers every falling clock edge from the first write. It opens the second write exactly WINDOW_CYC cycles after the first, then one cycle later, and checks the cycle in which `busy` rises. Each small page is swept with computed byte masks, including full pages. The whole array is then read back against a model in the bench.

// File: rtl/plc_pkg.sv
package plc_pkg;
  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_GATHER = 2'd1,
    PH_BURN   = 2'd2
  } phase_e;

  typedef logic [7:0] byte_t;
endpackage

// File: rtl/plc_strobe.sv
// Turns the sampled strobe levels into single-cycle cycle events.
module plc_strobe (
  input  logic clk,
  input  logic rst_n,
  input  logic ce_n,
  input  logic we_n,
  input  logic oe_n,
  output logic opened,
  output logic closed,
  output logic dropped
);
  logic wr_now, wr_q;

  assign wr_now = ~ce_n & ~we_n & oe_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b0;
    else        wr_q <= wr_now;
  end

  // later of the two falling strobes
  assign opened  = wr_now & ~wr_q;
  // first of the two rising strobes
  assign closed  = ~wr_now & wr_q & (ce_n | we_n);
  // output enable pulled low in mid-cycle
  assign dropped = ~wr_now & wr_q & ~ce_n & ~we_n;
endmodule

// File: rtl/plc_seq.sv
// Page lock, byte-load window and programming timer.
module plc_seq
  import plc_pkg::*;
#(
  parameter int ADDR_W     = 10,
  parameter int PAGE_W     = 6,
  parameter int WINDOW_CYC = 5000,
  parameter int PROG_CYC   = 100000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              opened,
  input  logic              closed,
  input  logic              dropped,
  input  logic [ADDR_W-1:0] addr,
  input  byte_t             din,
  output logic              buf_we,
  output logic [PAGE_W-1:0] buf_off,
  output byte_t             buf_data,
  output logic              commit,
  output logic [ADDR_W-PAGE_W-1:0] page,
  output logic              busy,
  output logic              page_err
);
  localparam int PG_W  = ADDR_W - PAGE_W;
  localparam int TMR_W = $clog2(WINDOW_CYC + 1);
  localparam int PRG_W = (PROG_CYC > 2) ? $clog2(PROG_CYC) : 1;
  localparam logic [TMR_W-1:0] WIN_LOAD  = TMR_W'(WINDOW_CYC);
  localparam logic [PRG_W-1:0] PROG_LAST = PRG_W'(PROG_CYC - 1);

  phase_e            phase;
  logic [PG_W-1:0]   page_q;
  logic [PAGE_W-1:0] off_q;
  logic              acc_q;
  logic [TMR_W-1:0]  timer_q;
  logic [PRG_W-1:0]  prog_q;
  logic              err_q;
  logic [PG_W-1:0]   in_page;
  logic [PAGE_W-1:0] in_off;

  assign in_page = addr[ADDR_W-1:PAGE_W];
  assign in_off  = addr[PAGE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase   <= PH_IDLE;
      page_q  <= '0;
      off_q   <= '0;
      acc_q   <= 1'b0;
      timer_q <= '0;
      prog_q  <= '0;
      err_q   <= 1'b0;
    end else begin
      case (phase)
        PH_IDLE: begin
          if (opened) begin
            page_q  <= in_page;
            off_q   <= in_off;
            acc_q   <= 1'b1;
            timer_q <= WIN_LOAD;
            phase   <= PH_GATHER;
          end
        end
        PH_GATHER: begin
          if (timer_q == '0 && !acc_q) begin
            phase  <= PH_BURN;
            prog_q <= PROG_LAST;
          end else if (opened) begin
            if (in_page == page_q) begin
              off_q   <= in_off;
              acc_q   <= 1'b1;
              timer_q <= WIN_LOAD;
            end else begin
              err_q <= 1'b1;
              acc_q <= 1'b0;
              if (timer_q != '0) timer_q <= timer_q - 1'b1;
            end
          end else begin
            if (closed || dropped) acc_q <= 1'b0;
            if (timer_q != '0) timer_q <= timer_q - 1'b1;
          end
        end
        PH_BURN: begin
          acc_q <= 1'b0;
          if (prog_q == '0) phase <= PH_IDLE;
          else              prog_q <= prog_q - 1'b1;
        end
        default: phase <= PH_IDLE;
      endcase
    end
  end

  assign buf_we   = closed & acc_q;
  assign buf_off  = off_q;
  assign buf_data = din;
  assign commit   = (phase == PH_BURN) && (prog_q == '0);
  assign page     = page_q;
  assign busy     = (phase == PH_BURN);
  assign page_err = err_q;

  // run length of busy, kept for the checks below
  localparam int RUN_W = $clog2(PROG_CYC + 2);
  logic [RUN_W-1:0] busy_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else           busy_run <= '0;
  end

  assert_err_sticky_R4: assert property (@(posedge clk) disable iff (!rst_n)
    page_err |=> page_err);

  assert_mismatch_dropped_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (opened && phase == PH_GATHER && in_page != page_q && !(timer_q == '0)) |=> !acc_q);

  assert_window_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_GATHER) |-> (timer_q <= WIN_LOAD));

  assert_busy_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (busy_run == RUN_W'(PROG_CYC)));

  assert_commit_then_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> !busy);

  assert_no_load_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !buf_we);
endmodule

// File: rtl/plc_pagebuf.sv
// One byte register and one loaded flag per page offset.
module plc_pagebuf
  import plc_pkg::*;
#(
  parameter int PAGE_W = 6
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [PAGE_W-1:0]        wr_off,
  input  byte_t                    wr_data,
  input  logic                     clr,
  output logic [(1<<PAGE_W)-1:0][7:0] data_o,
  output logic [(1<<PAGE_W)-1:0]   mask_o
);
  localparam int PAGE = 1 << PAGE_W;

  for (genvar g = 0; g < PAGE; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        data_o[g] <= '0;
        mask_o[g] <= 1'b0;
      end else if (clr) begin
        mask_o[g] <= 1'b0;
      end else if (wr_en && wr_off == PAGE_W'(g)) begin
        data_o[g] <= wr_data;
        mask_o[g] <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/plc_array.sv
// Register array: whole-page masked commit, registered read.
module plc_array
  import plc_pkg::*;
#(
  parameter int    ADDR_W = 10,
  parameter int    PAGE_W = 6,
  parameter byte_t ERASED = 8'hFF
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        commit,
  input  logic [ADDR_W-PAGE_W-1:0]    commit_page,
  input  logic [(1<<PAGE_W)-1:0][7:0] page_data,
  input  logic [(1<<PAGE_W)-1:0]      page_mask,
  input  logic [ADDR_W-1:0]           rd_addr,
  output byte_t                       rd_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam int PAGE  = 1 << PAGE_W;

  byte_t mem [DEPTH];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= ERASED;
    end else if (commit) begin
      for (int j = 0; j < PAGE; j++)
        if (page_mask[j]) mem[{commit_page, PAGE_W'(j)}] <= page_data[j];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= ERASED;
    else        rd_data <= mem[rd_addr];
  end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import plc_pkg::*;
#(
  parameter int    ADDR_W     = 10,
  parameter int    PAGE_W     = 6,
  parameter int    WINDOW_CYC = 5000,
  parameter int    PROG_CYC   = 100000,
  parameter byte_t ERASED     = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ce_n,
  input  logic              we_n,
  input  logic              oe_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [7:0]        din,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]        rd_data,
  output logic              busy,
  output logic              page_err
);
  localparam int PG_W = ADDR_W - PAGE_W;
  localparam int PAGE = 1 << PAGE_W;

  logic                      opened, closed, dropped;
  logic                      buf_we, commit;
  logic [PAGE_W-1:0]         buf_off;
  byte_t                     buf_data;
  logic [PG_W-1:0]           page;
  logic [PAGE-1:0][7:0]      pg_data;
  logic [PAGE-1:0]           pg_mask;

  plc_strobe u_strobe (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .opened(opened), .closed(closed), .dropped(dropped)
  );

  plc_seq #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W),
    .WINDOW_CYC(WINDOW_CYC), .PROG_CYC(PROG_CYC)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .opened(opened), .closed(closed), .dropped(dropped),
    .addr(addr), .din(din), .buf_we(buf_we), .buf_off(buf_off), .buf_data(buf_data),
    .commit(commit), .page(page), .busy(busy), .page_err(page_err)
  );

  plc_pagebuf #(.PAGE_W(PAGE_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(buf_we), .wr_off(buf_off), .wr_data(buf_data),
    .clr(commit), .data_o(pg_data), .mask_o(pg_mask)
  );

  plc_array #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .ERASED(ERASED)) u_arr (
    .clk(clk), .rst_n(rst_n), .commit(commit), .commit_page(page),
    .page_data(pg_data), .page_mask(pg_mask), .rd_addr(rd_addr), .rd_data(rd_data)
  );

  assert_oe_low_blocks_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !oe_n |-> !buf_we);

  assert_ignored_when_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !commit) |=> busy);
endmodule

// File: tb/page_load_ctrl_tb.sv
module page_load_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 8;
  localparam int PW = 3;
  localparam int W  = 12;
  localparam int P  = 20;
  localparam int SETTLE = W + P + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ce_n = 1'b1, we_n = 1'b1, oe_n = 1'b1;
  logic [AW-1:0] addr = '0, rd_addr = '0;
  logic [7:0] din = '0;
  logic [7:0] rd_data;
  logic busy, page_err;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [7:0] ref_mem [256];

  page_load_ctrl #(.ADDR_W(AW), .PAGE_W(PW), .WINDOW_CYC(W), .PROG_CYC(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .we_n(we_n), .oe_n(oe_n),
    .addr(addr), .din(din), .rd_addr(rd_addr), .rd_data(rd_data),
    .busy(busy), .page_err(page_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d);
    @(negedge clk) rd_addr = a;
    @(negedge clk) d = rd_data;
  endtask

  // write-strobe driven load: low for 2 cycles, high for 1
  task automatic ld(input logic [7:0] a, input logic [7:0] d);
    addr = a; din = d; ce_n = 1'b0; we_n = 1'b0;
    idle(2);
    we_n = 1'b1; ce_n = 1'b1;
    idle(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int rise, fall;
    for (int i = 0; i < 256; i++) ref_mem[i] = 8'hFF;
    idle(3);
    rst_n = 1'b1;
    idle(1);

    // R9: reset state
    chk(busy, 0, "R9 busy after reset");
    chk(page_err, 0, "R9 err after reset");
    rd(8'h00, v); chk(v, 8'hFF, "R9 erased byte 00");
    rd(8'hFF, v); chk(v, 8'hFF, "R9 erased byte FF");

    // R6 busy span and old data during busy; R7 write while busy ignored
    rd_addr = 8'h10; rise = 0; fall = 0;
    addr = 8'h10; din = 8'h5A; ce_n = 0; we_n = 0;
    for (int m = 1; m <= W + P + 8; m++) begin
      @(negedge clk);
      if (busy && rise == 0) rise = m;
      if (!busy && rise != 0 && fall == 0) fall = m;
      if (m == W + 1 + P) chk(rd_data, 8'hFF, "R6 old data while busy");
      if (m == W + 3 + P) chk(rd_data, 8'h5A, "R6 new data after busy");
      if (m == 2) begin we_n = 1; ce_n = 1; end
      if (m == W + 5) begin addr = 8'h11; din = 8'h77; ce_n = 0; we_n = 0; end
      if (m == W + 7) begin we_n = 1; ce_n = 1; end
    end
    chk(rise, W + 2, "R6 busy rise cycle");
    chk(fall, W + 2 + P, "R6 busy fall cycle");
    chk(busy, 0, "R7 no new operation from busy write");
    ref_mem[8'h10] = 8'h5A;
    rd(8'h11, v); chk(v, 8'hFF, "R7 byte written during busy ignored");

    // R5 second load opens exactly W cycles later: joins the page
    addr = 8'h20; din = 8'hA1; ce_n = 0; we_n = 0;
    for (int m = 1; m <= W + 3; m++) begin
      @(negedge clk);
      if (m == 2) begin we_n = 1; ce_n = 1; end
      if (m == W) begin addr = 8'h27; din = 8'hA7; ce_n = 0; we_n = 0; end
      if (m == W + 2) begin we_n = 1; ce_n = 1; end
    end
    idle(SETTLE);
    ref_mem[8'h20] = 8'hA1; ref_mem[8'h27] = 8'hA7;
    rd(8'h27, v); chk(v, 8'hA7, "R5 load at window edge kept");
    rd(8'h21, v); chk(v, 8'hFF, "R5 unloaded byte of page unchanged");

    // R5 second load one cycle late: lost, busy already high
    addr = 8'h30; din = 8'hB0; ce_n = 0; we_n = 0;
    for (int m = 1; m <= W + 4; m++) begin
      @(negedge clk);
      if (m == W + 2) chk(busy, 1, "R5 programming after window expiry");
      if (m == 2) begin we_n = 1; ce_n = 1; end
      if (m == W + 1) begin addr = 8'h31; din = 8'hB1; ce_n = 0; we_n = 0; end
      if (m == W + 3) begin we_n = 1; ce_n = 1; end
    end
    idle(SETTLE);
    ref_mem[8'h30] = 8'hB0;
    rd(8'h31, v); chk(v, 8'hFF, "R5 late load lost");
    rd(8'h30, v); chk(v, 8'hB0, "R5 first load written");

    // R2 R3: chip-select controlled cycle
    addr = 8'h41; din = 8'h11; we_n = 0; ce_n = 1;
    idle(1); addr = 8'h42; ce_n = 0;
    idle(1); addr = 8'h43; din = 8'h22;
    idle(1); din = 8'h33;
    idle(1); ce_n = 1;
    idle(1); we_n = 1;
    idle(SETTLE);
    ref_mem[8'h42] = 8'h33;
    rd(8'h42, v); chk(v, 8'h33, "R2 R3 address at open, data at close");
    rd(8'h43, v); chk(v, 8'hFF, "R2 later address not used");
    rd(8'h41, v); chk(v, 8'hFF, "R2 address before open not used");

    // R1 R8: output enable low blocks writing
    rise = 0;
    addr = 8'h50; din = 8'h44; oe_n = 0; ce_n = 0; we_n = 0;
    for (int m = 1; m <= SETTLE; m++) begin
      @(negedge clk);
      if (busy) rise = 1;
      if (m == 3) begin we_n = 1; ce_n = 1; oe_n = 1; end
    end
    chk(rise, 0, "R1 no operation with oe low");
    rd(8'h50, v); chk(v, 8'hFF, "R1 byte not written with oe low");

    // R8: oe pulse between loads keeps page open
    rise = 0;
    ld(8'h58, 8'hC8);
    oe_n = 0; @(negedge clk); rise |= busy; @(negedge clk); rise |= busy; oe_n = 1;
    ld(8'h59, 8'hC9);
    chk(rise, 0, "R8 no programming during oe pulse");
    idle(SETTLE);
    ref_mem[8'h58] = 8'hC8; ref_mem[8'h59] = 8'hC9;
    rd(8'h58, v); chk(v, 8'hC8, "R8 byte before oe pulse");
    rd(8'h59, v); chk(v, 8'hC9, "R8 byte after oe pulse");

    // R4: mismatched page dropped, flag set, window not restarted
    chk(page_err, 0, "R4 no error yet");
    rise = 0;
    addr = 8'h60; din = 8'hD0; ce_n = 0; we_n = 0;
    for (int m = 1; m <= W + 4; m++) begin
      @(negedge clk);
      if (busy && rise == 0) rise = m;
      if (m == W - 2) chk(page_err, 1, "R4 error flag on page mismatch");
      if (m == 2) begin we_n = 1; ce_n = 1; end
      if (m == W - 3) begin addr = 8'h70; din = 8'hE0; ce_n = 0; we_n = 0; end
      if (m == W - 1) begin we_n = 1; ce_n = 1; end
    end
    chk(rise, W + 2, "R4 window not restarted by dropped load");
    idle(SETTLE);
    ref_mem[8'h60] = 8'hD0;
    rd(8'h70, v); chk(v, 8'hFF, "R4 mismatched byte dropped");
    rd(8'h60, v); chk(v, 8'hD0, "R4 locked page byte written");

    // R11: oe falls mid-cycle, byte abandoned
    addr = 8'h80; din = 8'h99; ce_n = 0; we_n = 0;
    idle(1); oe_n = 0;
    idle(1); ce_n = 1; we_n = 1; oe_n = 1;
    idle(SETTLE);
    rd(8'h80, v); chk(v, 8'hFF, "R11 abandoned cycle not loaded");

    // R10 R5: sweep every page with computed masks, full pages included
    for (int p = 0; p < 32; p++) begin
      logic [7:0] mask;
      mask = (p % 4 == 0) ? 8'hFF : (8'((p * 37 + 11)) | 8'(1 << (p % 8)));
      for (int o = 0; o < 8; o++) begin
        if (mask[o]) begin
          logic [7:0] a, d;
          a = 8'(p * 8 + o);
          d = 8'((p * 13 + o * 7 + 3)) ^ 8'h5C;
          ld(a, d);
          ref_mem[a] = d;
        end
      end
      idle(SETTLE);
    end
    for (int a = 0; a < 256; a++) begin
      rd(8'(a), v);
      chk(v, ref_mem[a], $sformatf("R10 R5 readback addr %0h", a));
    end
    chk(page_err, 1, "R4 error flag still set");

    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule